// File: doc/BRIEF.md
# Cycle-Stealing Four-Channel DMA Controller

This block moves blocks of bytes between I/O devices and memory without the processor handling each byte. Each of four channels holds a start address, a byte count, a direction and an enable bit. Software writes these through a small write-only configuration port while the channel is switched off, then switches it on. From then on, the attached device's request line drives the transfers.

For each byte the controller raises a bus request to the processor and waits for the grant. It then owns the address and strobe lines for exactly one clock, acknowledging the device in that same clock. After that it drops its request and waits for the grant to fall before it may ask again, so the processor gets the bus back between stolen cycles. A fixed priority picks among channels that want service at the same time. The final byte of a block raises a per-channel terminal-count pulse that serves as the processor's interrupt, and the channel switches itself off.

The sequencer has four states:
- ST_IDLE: the bus is released. It moves to ST_ASK when an enabled channel has its request high.
- ST_ASK: the bus request is held. It moves to ST_MOVE when the grant arrives.
- ST_MOVE: one byte is transferred. It always moves to ST_YIELD.
- ST_YIELD: the request is dropped. It returns to ST_IDLE once the grant has fallen.

Top module: `cyc_steal_dma`

## Requirements
- R1: While reset is active and right after it, hold_req, bus_own, all strobes, dev_ack, tc_pulse and bus_addr are zero, and every channel is disabled.
- R2: A configuration write (cfg_we high for one clock) to channel cfg_chan selects a field with cfg_sel: 0 start address, 1 count, 2 direction (data bit 0), 3 enable (data bit 0). Writes to fields 0 to 2 of a channel whose enable is set are ignored.
- R3: When an enabled channel's dev_req is high, hold_req rises. The controller never drives the bus (bus_own, strobes, dev_ack) until hold_grant is high, however long the grant is withheld.
- R4: Each grant carries exactly one byte: bus_own and a single dev_ack bit are high for one clock. In the next clock hold_req is low, and it stays low until hold_grant has fallen.
- R5: Direction 0 moves device to memory (bus_io_rd and bus_mem_wr high in the transfer clock). Direction 1 moves memory to device (bus_mem_rd and bus_io_wr high). No strobe is high outside a transfer clock.
- R6: bus_addr carries the channel's current address during its transfer clock. After each byte the address increments by one, wrapping modulo 2^16, and the count decrements by one.
- R7: A programmed count of N moves N+1 bytes. The tc_pulse bit of the channel is high in the transfer clock of the last byte, where the count is zero. The channel then clears its enable and ignores its request until it is enabled again.
- R8: When several enabled channels request at the same time, the lowest-numbered one is served. Requests from disabled channels are ignored.
- R9: A write to the enable field that lands in a channel's transfer clock does not stop that byte. A disable written there stops the block after that byte. A terminal-count clear in that clock overrides a write that sets the enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_chan | input | 2 | Channel addressed by the write |
| cfg_sel | input | 2 | Field select: 0 address, 1 count, 2 direction, 3 enable |
| cfg_wdata | input | 16 | Write data |
| dev_req | input | 4 | Per-channel device request |
| dev_ack | output | 4 | Per-channel acknowledge, high in the transfer clock |
| hold_req | output | 1 | Bus request to the processor |
| hold_grant | input | 1 | Bus grant from the processor |
| bus_own | output | 1 | High while the controller drives address and strobes |
| bus_addr | output | 16 | Memory address of the current byte |
| bus_mem_rd | output | 1 | Memory read strobe |
| bus_mem_wr | output | 1 | Memory write strobe |
| bus_io_rd | output | 1 | Device read strobe |
| bus_io_wr | output | 1 | Device write strobe |
| tc_pulse | output | 4 | Per-channel terminal count, used as the interrupt |

## Verification
Two things can land on a channel's enable bit in the same clock: a software write to that bit, and the transfer-clock update that may clear it at terminal count. The bench creates this collision on purpose. It waits at the falling edge for the channel's acknowledge and then drives the enable write, so the write takes effect on the edge that ends the transfer. The outcome is judged only at the ports. After a disable landing on the first byte, exactly one byte must have moved, even though the request stays high. After a set-enable landing on the final byte, only the programmed bytes may appear, with one terminal-count pulse and no later acknowledge.

// File: rtl/csd_pkg.sv
package csd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ASK   = 2'd1,
        ST_MOVE  = 2'd2,
        ST_YIELD = 2'd3
    } csd_state_t;

    localparam logic [1:0] SEL_ADDR = 2'd0;
    localparam logic [1:0] SEL_CNT  = 2'd1;
    localparam logic [1:0] SEL_DIR  = 2'd2;
    localparam logic [1:0] SEL_EN   = 2'd3;

    localparam logic DIR_DEV2MEM = 1'b0;
    localparam logic DIR_MEM2DEV = 1'b1;

endpackage

// File: rtl/csd_chan_regs.sv
module csd_chan_regs
    import csd_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int CW  = 16,
    parameter int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [CHW-1:0] cfg_chan,
    input  logic [1:0]     cfg_sel,
    input  logic [AW-1:0]  cfg_wdata,
    input  logic           step,
    input  logic [CHW-1:0] step_ch,
    output logic [AW-1:0]  ch_addr [NCH],
    output logic           ch_dir  [NCH],
    output logic           ch_last [NCH],
    output logic [NCH-1:0] ch_en
);

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic [AW-1:0] addr_q;
        logic [CW-1:0] cnt_q;
        logic          dir_q;
        logic          en_q;
        logic          hit;
        logic          stp;
        logic          last;

        assign hit  = cfg_we && (cfg_chan == CHW'(g));
        assign stp  = step && (step_ch == CHW'(g));
        assign last = (cnt_q == '0);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_q <= '0;
                cnt_q  <= '0;
                dir_q  <= DIR_DEV2MEM;
            end else begin
                if (hit && !en_q) begin
                    if (cfg_sel == SEL_ADDR) addr_q <= cfg_wdata;
                    if (cfg_sel == SEL_CNT)  cnt_q  <= cfg_wdata[CW-1:0];
                    if (cfg_sel == SEL_DIR)  dir_q  <= cfg_wdata[0];
                end
                if (stp) begin
                    addr_q <= addr_q + 1'b1;
                    cnt_q  <= cnt_q - 1'b1;
                end
            end
        end

        // terminal-count clear outranks a software write in the same clock
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q <= 1'b0;
            end else if (stp && last) begin
                en_q <= 1'b0;
            end else if (hit && (cfg_sel == SEL_EN)) begin
                en_q <= cfg_wdata[0];
            end
        end

        assign ch_addr[g] = addr_q;
        assign ch_dir[g]  = dir_q;
        assign ch_last[g] = last;
        assign ch_en[g]   = en_q;
    end

endmodule

// File: rtl/csd_arbiter.sv
module csd_arbiter #(
    parameter int NCH = 4,
    parameter int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0] cand,
    output logic           any,
    output logic [CHW-1:0] idx
);

    always_comb begin
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (cand[i]) idx = CHW'(i);
        end
        any = |cand;
    end

endmodule

// File: rtl/csd_seq.sv
module csd_seq
    import csd_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pend_any,
    input  logic [CHW-1:0] pend_idx,
    input  logic           hold_grant,
    output logic           hold_req,
    output logic           move,
    output logic [CHW-1:0] cur_ch
);

    csd_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_ch <= '0;
        end else if (state_q == ST_IDLE && pend_any) begin
            cur_ch <= pend_idx;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (pend_any)    state_d = ST_ASK;
            ST_ASK:   if (hold_grant)  state_d = ST_MOVE;
            ST_MOVE:                   state_d = ST_YIELD;
            ST_YIELD: if (!hold_grant) state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        hold_req = 1'b0;
        move     = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_ASK:   hold_req = 1'b1;
            ST_MOVE:  begin hold_req = 1'b1; move = 1'b1; end
            ST_YIELD: ;
        endcase
    end

endmodule

// File: rtl/cyc_steal_dma.sv
module cyc_steal_dma
    import csd_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int CW  = 16,
    parameter int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [CHW-1:0] cfg_chan,
    input  logic [1:0]     cfg_sel,
    input  logic [AW-1:0]  cfg_wdata,
    input  logic [NCH-1:0] dev_req,
    output logic [NCH-1:0] dev_ack,
    output logic           hold_req,
    input  logic           hold_grant,
    output logic           bus_own,
    output logic [AW-1:0]  bus_addr,
    output logic           bus_mem_rd,
    output logic           bus_mem_wr,
    output logic           bus_io_rd,
    output logic           bus_io_wr,
    output logic [NCH-1:0] tc_pulse
);

    localparam logic [NCH-1:0] ONE = NCH'(1);

    logic [AW-1:0]  ch_addr [NCH];
    logic           ch_dir  [NCH];
    logic           ch_last [NCH];
    logic [NCH-1:0] ch_en;
    logic           pend_any;
    logic [CHW-1:0] pend_idx;
    logic           move;
    logic [CHW-1:0] cur_ch;

    csd_chan_regs #(.NCH(NCH), .AW(AW), .CW(CW), .CHW(CHW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_chan  (cfg_chan),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .step      (move),
        .step_ch   (cur_ch),
        .ch_addr   (ch_addr),
        .ch_dir    (ch_dir),
        .ch_last   (ch_last),
        .ch_en     (ch_en)
    );

    csd_arbiter #(.NCH(NCH), .CHW(CHW)) u_arb (
        .cand (dev_req & ch_en),
        .any  (pend_any),
        .idx  (pend_idx)
    );

    csd_seq #(.NCH(NCH), .CHW(CHW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_any   (pend_any),
        .pend_idx   (pend_idx),
        .hold_grant (hold_grant),
        .hold_req   (hold_req),
        .move       (move),
        .cur_ch     (cur_ch)
    );

    always_comb begin
        bus_own    = move;
        bus_addr   = move ? ch_addr[cur_ch] : '0;
        bus_mem_rd = move && (ch_dir[cur_ch] == DIR_MEM2DEV);
        bus_io_wr  = move && (ch_dir[cur_ch] == DIR_MEM2DEV);
        bus_io_rd  = move && (ch_dir[cur_ch] == DIR_DEV2MEM);
        bus_mem_wr = move && (ch_dir[cur_ch] == DIR_DEV2MEM);
        dev_ack    = move ? (ONE << cur_ch) : '0;
        tc_pulse   = (move && ch_last[cur_ch]) ? (ONE << cur_ch) : '0;
    end

endmodule

// File: rtl/csd_chk.sv
module csd_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           hold_req,
    input logic           hold_grant,
    input logic           bus_own,
    input logic [NCH-1:0] dev_ack,
    input logic [NCH-1:0] tc_pulse,
    input logic           bus_mem_rd,
    input logic           bus_mem_wr,
    input logic           bus_io_rd,
    input logic           bus_io_wr
);

    // R3
    own_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_own |-> (hold_grant && hold_req));

    // R3
    own_follows_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_own) |-> $past(hold_req && hold_grant));

    // R4
    one_byte_per_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_own |=> (!bus_own && !hold_req));

    // R4
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_own |-> ($countones(dev_ack) == 1));

    // R4
    ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_own |-> (dev_ack == '0));

    // R4
    no_reask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_req && hold_grant) |=> !hold_req);

    // R5
    strobe_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_own |-> ((bus_mem_rd == bus_io_wr) && (bus_mem_wr == bus_io_rd)
                     && (bus_mem_rd != bus_mem_wr)));

    // R5
    strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_own |-> !(bus_mem_rd || bus_mem_wr || bus_io_rd || bus_io_wr));

    // R7
    tc_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tc_pulse) && ((tc_pulse & ~dev_ack) == '0));

endmodule

bind cyc_steal_dma csd_chk #(.NCH(NCH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_req   (hold_req),
    .hold_grant (hold_grant),
    .bus_own    (bus_own),
    .dev_ack    (dev_ack),
    .tc_pulse   (tc_pulse),
    .bus_mem_rd (bus_mem_rd),
    .bus_mem_wr (bus_mem_wr),
    .bus_io_rd  (bus_io_rd),
    .bus_io_wr  (bus_io_wr)
);

// File: tb/sim_cyc_steal_dma.sv
module sim_cyc_steal_dma;

    localparam int NCH = 4;
    localparam int AW  = 16;
    localparam int CW  = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_we = 1'b0;
    logic [1:0]     cfg_chan = '0;
    logic [1:0]     cfg_sel = '0;
    logic [AW-1:0]  cfg_wdata = '0;
    logic [NCH-1:0] dev_req = '0;
    logic [NCH-1:0] dev_ack;
    logic           hold_req;
    logic           hold_grant = 1'b0;
    logic           bus_own;
    logic [AW-1:0]  bus_addr;
    logic           bus_mem_rd, bus_mem_wr, bus_io_rd, bus_io_wr;
    logic [NCH-1:0] tc_pulse;

    always #5 clk = ~clk;

    cyc_steal_dma #(.NCH(NCH), .AW(AW), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_chan(cfg_chan),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .dev_req(dev_req),
        .dev_ack(dev_ack), .hold_req(hold_req), .hold_grant(hold_grant),
        .bus_own(bus_own), .bus_addr(bus_addr), .bus_mem_rd(bus_mem_rd),
        .bus_mem_wr(bus_mem_wr), .bus_io_rd(bus_io_rd), .bus_io_wr(bus_io_wr),
        .tc_pulse(tc_pulse)
    );

    // bench reference model of the channels
    logic [AW-1:0] m_addr [NCH];
    logic [CW-1:0] m_cnt  [NCH];
    logic          m_dir  [NCH];
    logic          m_en   [NCH];
    int            n_xfer [NCH];
    int            n_tc   [NCH];

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    bit stall_grant = 0;
    bit prev_move = 0;

    task automatic chk_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_winner();
        for (int i = 0; i < NCH; i++)
            if (m_en[i] && dev_req[i]) return i;
        return -1;
    endfunction

    // {mem_rd, mem_wr, io_rd, io_wr}
    function automatic logic [3:0] exp_strobe(input logic dir);
        return dir ? 4'b1001 : 4'b0110;
    endfunction

    function automatic void model_wr(input int ch, input logic [1:0] sel, input logic [15:0] d);
        if (sel == 2'd3) m_en[ch] = d[0];
        else if (!m_en[ch]) begin
            if (sel == 2'd0) m_addr[ch] = d;
            if (sel == 2'd1) m_cnt[ch]  = d;
            if (sel == 2'd2) m_dir[ch]  = d[0];
        end
    endfunction

    task automatic cfg_wr(input int ch, input logic [1:0] sel, input logic [15:0] d, input bit upd);
        @(negedge clk);
        cfg_we = 1'b1; cfg_chan = 2'(ch); cfg_sel = sel; cfg_wdata = d;
        if (upd) model_wr(ch, sel, d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic setup_ch(input int ch, input logic [15:0] a, input logic [15:0] c,
                            input logic dir, input logic en);
        cfg_wr(ch, 2'd3, 16'd0, 1);
        cfg_wr(ch, 2'd0, a, 1);
        cfg_wr(ch, 2'd1, c, 1);
        cfg_wr(ch, 2'd2, {15'd0, dir}, 1);
        cfg_wr(ch, 2'd3, {15'd0, en}, 1);
    endtask

    task automatic wait_idle(input string req);
        bit ok = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (exp_winner() < 0 && !hold_req && !hold_grant) begin ok = 1; break; end
        end
        repeat (4) @(negedge clk);
        chk_eq(req, {63'd0, ok}, 64'd1);
    endtask

    task automatic wait_ack(input int ch, input bit need_tc);
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (dev_ack[ch] && (!need_tc || tc_pulse[ch])) break;
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // processor model and transfer monitor, both at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                hold_grant = 1'b0;
                prev_move = 0;
            end else begin
                if (prev_move) chk_eq("R4 bus released after byte", {hold_req, bus_own}, 0);
                if (bus_own || dev_ack != '0) begin
                    int w;
                    w = exp_winner();
                    if (w < 0) begin
                        chk_eq("R8 unexpected transfer", dev_ack, 0);
                    end else begin
                        chk_eq("R8 served channel", dev_ack, 64'(1) << w);
                        chk_eq("R6 address", bus_addr, m_addr[w]);
                        chk_eq("R5 strobes", {bus_mem_rd, bus_mem_wr, bus_io_rd, bus_io_wr},
                               exp_strobe(m_dir[w]));
                        chk_eq("R7 terminal count", tc_pulse,
                               (m_cnt[w] == '0) ? (64'(1) << w) : 0);
                        chk_eq("R3 grant held", {bus_own, hold_grant}, 2'b11);
                        n_xfer[w]++;
                        if (m_cnt[w] == '0) begin n_tc[w]++; m_en[w] = 1'b0; end
                        m_addr[w] = m_addr[w] + 1'b1;
                        m_cnt[w]  = m_cnt[w] - 1'b1;
                    end
                    prev_move = 1;
                end else begin
                    prev_move = 0;
                end
                hold_grant = stall_grant ? 1'b0 : hold_req;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        int b0, b1, b2, b3, t3;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NCH; i++) begin
            m_addr[i] = '0; m_cnt[i] = '0; m_dir[i] = 1'b0; m_en[i] = 1'b0;
            n_xfer[i] = 0; n_tc[i] = 0;
        end
        repeat (3) @(negedge clk);
        // R1 during and after reset
        chk_eq("R1 outputs in reset", {hold_req, bus_own, dev_ack, tc_pulse, bus_addr,
               bus_mem_rd, bus_mem_wr, bus_io_rd, bus_io_wr}, 0);
        rst_n = 1'b1;
        dev_req = 4'hF;
        repeat (6) @(negedge clk);
        chk_eq("R1 channels disabled after reset", {hold_req, bus_own, dev_ack}, 0);
        dev_req = '0;

        // R7: count 0 moves one byte, then the channel ignores its request
        setup_ch(1, 16'h1234, 16'd0, 1'b1, 1'b1);
        dev_req = 4'b0010;
        wait_idle("R7 idle");
        chk_eq("R7 one byte for count 0", n_xfer[1], 1);
        chk_eq("R7 one tc pulse", n_tc[1], 1);
        repeat (10) @(negedge clk);
        chk_eq("R7 request ignored after tc", {n_xfer[1], hold_req}, {32'd1, 1'b0});
        dev_req = '0;

        // R2: programming writes to an enabled channel are ignored
        setup_ch(0, 16'h0100, 16'd2, 1'b0, 1'b1);
        cfg_wr(0, 2'd0, 16'h0F00, 1);
        cfg_wr(0, 2'd1, 16'd9, 1);
        cfg_wr(0, 2'd2, 16'd1, 1);
        dev_req = 4'b0001;
        wait_idle("R2 idle");
        chk_eq("R2 byte count unchanged by protected write", n_xfer[0], 3);
        chk_eq("R2 address continues from protected value", m_addr[0], 16'h0103);
        dev_req = '0;

        // R8: fixed priority with three contenders
        b0 = n_xfer[0]; b2 = n_xfer[2]; b3 = n_xfer[3];
        setup_ch(0, 16'h2000, 16'd3, 1'b1, 1'b1);
        setup_ch(2, 16'h3000, 16'd1, 1'b0, 1'b1);
        setup_ch(3, 16'hFFFF, 16'd0, 1'b1, 1'b1);
        setup_ch(1, 16'h0000, 16'd5, 1'b0, 1'b0);
        dev_req = 4'b1111;
        wait_idle("R8 idle");
        chk_eq("R8 counts per channel", {n_xfer[0]-b0, n_xfer[2]-b2, n_xfer[3]-b3},
               {32'd4, 32'd2, 32'd1});
        chk_eq("R6 wrap of address", m_addr[3], 16'h0000);
        dev_req = '0;

        // R3: withheld grant keeps the bus undriven
        b2 = n_xfer[2];
        setup_ch(2, 16'h5000, 16'd0, 1'b0, 1'b1);
        stall_grant = 1;
        dev_req = 4'b0100;
        repeat (12) @(negedge clk);
        chk_eq("R3 waiting for grant", {hold_req, bus_own, dev_ack}, {1'b1, 1'b0, 4'b0000});
        stall_grant = 0;
        wait_idle("R3 idle");
        chk_eq("R3 byte after grant", n_xfer[2] - b2, 1);
        dev_req = '0;

        // R9: disable landing in the first transfer clock
        b1 = n_xfer[1];
        setup_ch(1, 16'h6000, 16'd3, 1'b0, 1'b1);
        dev_req = 4'b0010;
        wait_ack(1, 0);
        cfg_we = 1'b1; cfg_chan = 2'd1; cfg_sel = 2'd3; cfg_wdata = 16'd0;
        @(negedge clk);
        cfg_we = 1'b0;
        m_en[1] = 1'b0;
        repeat (20) @(negedge clk);
        chk_eq("R9 disable stops block after current byte", n_xfer[1] - b1, 1);
        dev_req = '0;

        // R9: set-enable write colliding with terminal count loses
        b3 = n_xfer[3]; t3 = n_tc[3];
        setup_ch(3, 16'h7000, 16'd1, 1'b1, 1'b1);
        dev_req = 4'b1000;
        wait_ack(3, 1);
        cfg_we = 1'b1; cfg_chan = 2'd3; cfg_sel = 2'd3; cfg_wdata = 16'd1;
        @(negedge clk);
        cfg_we = 1'b0;
        repeat (20) @(negedge clk);
        chk_eq("R9 tc clear wins over set", {n_xfer[3] - b3, n_tc[3] - t3}, {32'd2, 32'd1});
        chk_eq("R9 channel stays idle", {hold_req, bus_own}, 0);
        dev_req = '0;

        // random rounds
        for (int r = 0; r < 8; r++) begin
            logic [CW-1:0] cnt_s [NCH];
            logic          en_s  [NCH];
            int            base  [NCH];
            logic [NCH-1:0] mask;
            dev_req = '0;
            for (int c = 0; c < NCH; c++) begin
                cnt_s[c] = CW'($urandom % 5);
                en_s[c]  = ($urandom % 4) != 0;
                setup_ch(c, 16'($urandom), cnt_s[c], 1'($urandom % 2), en_s[c]);
                base[c] = n_xfer[c];
            end
            mask = NCH'($urandom % 16);
            dev_req = mask;
            wait_idle("R8 random idle");
            for (int c = 0; c < NCH; c++)
                chk_eq("R7 random bytes per channel", n_xfer[c] - base[c],
                       (en_s[c] && mask[c]) ? 64'(cnt_s[c]) + 1 : 0);
        end
        dev_req = '0;

        finished = 1;
        summary();
        $finish;
    end

endmodule